// File: doc/BRIEF.md
# Capture-Capable Period Timer

This block is a 16-bit up-counter that software sets up through four registers on a small register bus. The counter advances on one edge of an external timer clock. That clock is oversampled by the system clock, and a configuration bit picks the rising or the falling edge. Arming takes two steps. Software first sets the enable bit. Counting then begins only after a start event arrives while the block is effectively enabled. The counter climbs to a programmable period value. On the next active edge it returns to zero. A period-match flag, a zero flag and a capture flag each have their own interrupt enable.

A capture or stop event copies the live count into a capture register. A readout-select bit decides whether the counter address exposes the raw count or the captured value. The output pin idles at a programmable level. It either pulses for one timer clock on each period match or toggles on each match. A strap input picks how enabling and disabling take effect. In delayed mode, a change of the enable bit takes effect only after three active timer-clock edges. In immediate mode it takes effect at once.

Register addresses: 0 control, 1 period, 2 count/capture, 3 flags. Control bits are: 7 enable, 6 clock edge (1 rising, 0 falling), 5 output mode (1 toggle, 0 pulse), 4 idle level (1 high), 3 readout select (1 raw count), 2 period interrupt enable, 1 zero interrupt enable, 0 capture interrupt enable. Flag bits are: 2 period, 1 zero, 0 capture.

Top module: `tmr_core`

## Requirements
- R1: After reset, all four registers read zero, and `tmr_out`, `tmr_irq` and `tmr_run` are low.
- R2: A start event sets the run state only while the block is effectively enabled. A start event at any other time is lost.
- R3: With `sync_sel` latched high, setting enable takes effect after three active timer edges. After enable is cleared, the counter still advances on three more active edges and then stops. With `sync_sel` latched low, both changes take effect at once.
- R4: The counter advances on rising timer edges when control bit 6 is 1 and on falling edges when it is 0. Bit 6 and `sync_sel` are sampled only while the block is effectively disabled.
- R5: While running, each active edge increments the count. When the count equals the period, the next active edge returns it to zero. Flag bit 2 sets on the step from period-1 to period. Flag bit 1 sets whenever the count goes from nonzero to zero.
- R6: With readout select 1, a write to address 2 loads the counter. Such a write never sets flag bit 2, even when the value written is the period. With readout select 0, a write to address 2 has no effect.
- R7: Capture and stop events load the capture register with the count, whatever the readout select. Address 2 reads the capture register when readout select is 0 and the count when it is 1.
- R8: Flag bit 0 sets on a capture event only while the run state is high.
- R9: A stop event clears the run state and control bit 7 in the next cycle. The count then holds.
- R10: Flags set regardless of their enables. Writing 1 to a flag bit clears it. `tmr_irq` is high exactly when some flag and its enable are both set.
- R11: In pulse mode, `tmr_out` shows the non-idle level from the period-match edge until the next active edge.
- R12: In toggle mode, `tmr_out` inverts on each period match. Control bit 4 sets the idle level, and it applies while the block is disabled too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tclk_in | input | 1 | External timer clock, oversampled |
| sync_sel | input | 1 | 1 selects delayed enable/disable |
| start_evt | input | 1 | Start event, one cycle |
| stop_evt | input | 1 | Stop event, one cycle |
| capt_evt | input | 1 | Capture event, one cycle |
| tmr_out | output | 1 | Timer output |
| tmr_irq | output | 1 | Interrupt request |
| tmr_run | output | 1 | Run state |

## Verification
A wrong count or a wrong wrap point shows on the count readback after the very next timer pulse. The flags and `tmr_out` show the same error at that edge. The sweeps over several period values reveal an off-by-one in the compare within one period. An error in the enable-delay chain or in the configuration latch does not show as a bad value. It shows as a start that is honoured or lost one pulse too early, or as a count that runs one edge too long after disable. A faulty capture path shows only when the readout select is flipped, because the readback at that moment returns a stale or live value instead of the captured one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTL_EN    = 7;
   localparam int CTL_CPOL  = 6;
   localparam int CTL_OM    = 5;
   localparam int CTL_OPOL  = 4;
   localparam int CTL_RDSEL = 3;
   localparam int CTL_PIE   = 2;
   localparam int CTL_ZIE   = 1;
   localparam int CTL_CIE   = 0;
   localparam int CTL_W     = 8;
   localparam int FLG_W     = 3;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_PERIOD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_FLAGS  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic period;
      logic zero;
      logic capt;
   } flags_t;
endpackage

// File: rtl/tmr_clkedge.sv
module tmr_clkedge #(
   parameter int IN_SYNC     = 2,
   parameter int SYNC_STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tclk_in,
   input  logic cpol_cfg,
   input  logic sync_cfg,
   input  logic en_req,
   output logic edge_o,
   output logic en_eff_o,
   output logic sync_l_o
);
   localparam int SR_W = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

   logic tclk_s;
   logic tclk_q;
   logic cpol_l;
   logic sync_l;
   logic en_eff;

   // input resynchronizer depth chosen by parameter
   generate
      if (IN_SYNC == 0) begin : g_nosync_in
         assign tclk_s = tclk_in;
      end else begin : g_sync_in
         logic [IN_SYNC-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= {ff_q[IN_SYNC-2+((IN_SYNC==1)?1:0):0], tclk_in};
         end
         assign tclk_s = ff_q[IN_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tclk_q <= 1'b0;
         cpol_l <= 1'b0;
         sync_l <= 1'b0;
      end else begin
         tclk_q <= tclk_s;
         if (!en_eff) begin
            cpol_l <= cpol_cfg;
            sync_l <= sync_cfg;
         end
      end
   end

   assign edge_o = cpol_l ? (tclk_s & ~tclk_q) : (~tclk_s & tclk_q);

   // enable delay chain; follows the request directly in immediate mode
   generate
      if (SR_W == 1) begin : g_chain1
         logic sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sr_q <= 1'b0;
            else if (!sync_l) sr_q <= en_req;
            else if (edge_o)  sr_q <= en_req;
         end
         assign en_eff = sync_l ? sr_q : en_req;
      end else begin : g_chainn
         logic [SR_W-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sr_q <= '0;
            else if (!sync_l) sr_q <= {SR_W{en_req}};
            else if (edge_o)  sr_q <= {sr_q[SR_W-2:0], en_req};
         end
         assign en_eff = sync_l ? sr_q[SR_W-1] : en_req;
      end
   endgenerate

   assign en_eff_o = en_eff;
   assign sync_l_o = sync_l;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   input  logic             en_eff_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             capt_i,
   input  logic             sw_wr_i,
   input  logic [CNT_W-1:0] sw_data_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             toggle_mode_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             run_o,
   output logic             act_o,
   output logic             set_p_o,
   output logic             set_z_o,
   output logic             set_c_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, nxt;
   logic             run_q, act_q, tick, wrap;

   assign tick = edge_i && run_q && en_eff_i;
   assign wrap = (cnt_q == period_i);
   assign nxt  = cnt_q + 1'b1;

   always_comb begin
      cnt_d = cnt_q;
      if (sw_wr_i)   cnt_d = sw_data_i;
      else if (tick) cnt_d = wrap ? '0 : nxt;
   end

   assign set_p_o = tick && !sw_wr_i && !wrap && (nxt == period_i);
   assign set_z_o = (cnt_d == '0) && (cnt_q != '0);
   assign set_c_o = capt_i && run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cap_q <= '0;
         run_q <= 1'b0;
         act_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (capt_i || stop_i) cap_q <= cnt_q;
         if (!en_eff_i || stop_i) run_q <= 1'b0;
         else if (start_i)        run_q <= 1'b1;
         if (!en_eff_i)           act_q <= 1'b0;
         else if (toggle_mode_i) begin
            if (set_p_o) act_q <= ~act_q;
         end else begin
            if (set_p_o)   act_q <= 1'b1;
            else if (tick) act_q <= 1'b0;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign cap_o = cap_q;
   assign run_o = run_q;
   assign act_o = act_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int IN_SYNC     = 2,
   parameter int SYNC_STAGES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             tclk_in,
   input  logic             sync_sel,
   input  logic             start_evt,
   input  logic             stop_evt,
   input  logic             capt_evt,
   output logic             tmr_out,
   output logic             tmr_irq,
   output logic             tmr_run
);
   localparam int PAD_C = CNT_W - CTL_W;
   localparam int PAD_F = CNT_W - FLG_W;

   if (CNT_W < CTL_W || CNT_W > 32) begin : g_bad_w
      $error("tmr_core: CNT_W must lie in 8..32");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 8) begin : g_bad_s
      $error("tmr_core: SYNC_STAGES must lie in 1..8");
   end
   if (IN_SYNC < 0 || IN_SYNC > 4) begin : g_bad_i
      $error("tmr_core: IN_SYNC must lie in 0..4");
   end

   logic [CTL_W-1:0] ctrl_q;
   logic [CNT_W-1:0] period_q;
   flags_t           flg_q, flg_set, flg_clr;
   logic [CNT_W-1:0] cnt_q, cap_q;
   logic             tick_edge, en_eff, sync_l, run_q, act_q;
   logic             set_p, set_z, set_c, cnt_wr;
   reg_sel_e         sel;

   assign sel    = reg_sel_e'(bus_addr);
   assign cnt_wr = bus_wr && (sel == REG_COUNT) && ctrl_q[CTL_RDSEL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
      end else begin
         if (bus_wr && sel == REG_CTRL)   ctrl_q   <= bus_wdata[CTL_W-1:0];
         if (bus_wr && sel == REG_PERIOD) period_q <= bus_wdata;
         if (stop_evt)                    ctrl_q[CTL_EN] <= 1'b0;
      end
   end

   tmr_clkedge #(.IN_SYNC(IN_SYNC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .tclk_in  (tclk_in),
      .cpol_cfg (ctrl_q[CTL_CPOL]),
      .sync_cfg (sync_sel),
      .en_req   (ctrl_q[CTL_EN]),
      .edge_o   (tick_edge),
      .en_eff_o (en_eff),
      .sync_l_o (sync_l)
   );

   tmr_count #(.CNT_W(CNT_W)) u_count (
      .clk           (clk),
      .rst_n         (rst_n),
      .edge_i        (tick_edge),
      .en_eff_i      (en_eff),
      .start_i       (start_evt),
      .stop_i        (stop_evt),
      .capt_i        (capt_evt),
      .sw_wr_i       (cnt_wr),
      .sw_data_i     (bus_wdata),
      .period_i      (period_q),
      .toggle_mode_i (ctrl_q[CTL_OM]),
      .cnt_o         (cnt_q),
      .cap_o         (cap_q),
      .run_o         (run_q),
      .act_o         (act_q),
      .set_p_o       (set_p),
      .set_z_o       (set_z),
      .set_c_o       (set_c)
   );

   assign flg_set = '{period: set_p, zero: set_z, capt: set_c};
   assign flg_clr = (bus_wr && sel == REG_FLAGS) ? flags_t'(bus_wdata[FLG_W-1:0]) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= (flg_q & ~flg_clr) | flg_set;
   end

   always_comb begin
      unique case (sel)
         REG_CTRL:   bus_rdata = {{PAD_C{1'b0}}, ctrl_q};
         REG_PERIOD: bus_rdata = period_q;
         REG_COUNT:  bus_rdata = ctrl_q[CTL_RDSEL] ? cnt_q : cap_q;
         default:    bus_rdata = {{PAD_F{1'b0}}, flg_q};
      endcase
   end

   assign tmr_irq = (flg_q.period & ctrl_q[CTL_PIE]) |
                    (flg_q.zero   & ctrl_q[CTL_ZIE]) |
                    (flg_q.capt   & ctrl_q[CTL_CIE]);
   assign tmr_out = ctrl_q[CTL_OPOL] ^ act_q;
   assign tmr_run = run_q;
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_eff,
   input logic             sync_l,
   input logic             run_q,
   input logic [7:0]       ctrl_q,
   input logic [2:0]       flg_q,
   input logic             cnt_wr,
   input logic             stop_evt,
   input logic             capt_evt,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cap_q,
   input logic             tick_edge,
   input logic             act_q,
   input logic             set_p
);
   // R2
   run_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_eff |=> !run_q);

   // R3
   immediate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_l && !ctrl_q[7]) |=> !run_q);

   // R9
   stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (!run_q && !ctrl_q[7]));

   // R7
   capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capt_evt || stop_evt) |=> (cap_q == $past(cnt_q)));

   // R6
   sw_write_no_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !flg_q[2]) |=> !flg_q[2]);

   // R11
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[5] && act_q && tick_edge && run_q && en_eff && !set_p) |=> !act_q);
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_eff    (en_eff),
   .sync_l    (sync_l),
   .run_q     (run_q),
   .ctrl_q    (ctrl_q),
   .flg_q     (flg_q),
   .cnt_wr    (cnt_wr),
   .stop_evt  (stop_evt),
   .capt_evt  (capt_evt),
   .cnt_q     (cnt_q),
   .cap_q     (cap_q),
   .tick_edge (tick_edge),
   .act_q     (act_q),
   .set_p     (set_p)
);

// File: tb/tmr_core_bench.sv
module tmr_core_bench;
   localparam logic [15:0] C_EN = 16'h80, C_CPOL = 16'h40, C_OM = 16'h20, C_OPOL = 16'h10;
   localparam logic [15:0] C_RD = 16'h08, C_PIE = 16'h04, C_ZIE = 16'h02, C_CIE = 16'h01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        tclk = 1'b0;
   logic        sync_sel = 1'b0;
   logic        start_evt = 1'b0, stop_evt = 1'b0, capt_evt = 1'b0;
   logic        tmr_out, tmr_irq, tmr_run;
   int          vec = 0, miss = 0;
   logic [15:0] v;

   always #5 clk = ~clk;

   tmr_core u_tmr_core (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tclk_in(tclk),
      .sync_sel(sync_sel), .start_evt(start_evt), .stop_evt(stop_evt),
      .capt_evt(capt_evt), .tmr_out(tmr_out), .tmr_irq(tmr_irq), .tmr_run(tmr_run)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic half(input logic lvl);
      tclk = lvl;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse();
      half(1'b1);
      half(1'b0);
   endtask

   task automatic fire(input int which);
      @(negedge clk);
      if (which == 0) start_evt = 1'b1;
      else if (which == 1) stop_evt = 1'b1;
      else capt_evt = 1'b1;
      @(negedge clk);
      start_evt = 1'b0; stop_evt = 1'b0; capt_evt = 1'b0;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      vec++; miss++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         chk("R1 reg", v, 0);
      end
      chk("R1 out", tmr_out, 0);
      chk("R1 irq", tmr_irq, 0);
      chk("R1 run", tmr_run, 0);

      // sweep of period values, immediate enable
      for (int p = 1; p <= 6; p++) begin
         wr(0, 0); wr(0, C_RD); wr(1, p[15:0]); wr(2, 0); wr(3, 7);
         wr(0, C_EN | C_CPOL | C_RD | C_PIE | C_ZIE);
         fire(0);
         chk("R2 run after start", tmr_run, 1);
         for (int k = 1; k <= 2 * (p + 1); k++) begin
            int e;
            e = k % (p + 1);
            pulse();
            rd(2, v);
            chk("R5 count", v, e);
            chk("R11 pulse out", tmr_out, (e == p));
            rd(3, v);
            chk("R5 flags", v, {13'd0, (e == p), (e == 0), 1'b0});
            chk("R10 irq", tmr_irq, (e == p) || (e == 0));
            wr(3, 7);
         end
      end

      // delayed enable
      wr(0, 0);
      sync_sel = 1'b1;
      wr(1, 5); wr(0, C_RD); wr(2, 0); wr(3, 7);
      wr(0, 16'hCF);
      pulse(); pulse();
      fire(0);
      chk("R3 start before 3 edges", tmr_run, 0);
      pulse();
      fire(0);
      chk("R2 start after 3 edges", tmr_run, 1);
      rd(2, v); chk("R3 no count before run", v, 0);
      pulse(); pulse();
      rd(2, v); chk("R5 count 2", v, 2);
      fire(2);
      rd(3, v); chk("R8 capture flag running", v, 1);
      chk("R10 capture irq", tmr_irq, 1);
      wr(3, 7);
      wr(0, 16'hC7);
      pulse();
      rd(2, v); chk("R7 capture readback", v, 2);
      wr(2, 9);
      wr(0, 16'hCF);
      rd(2, v); chk("R6 write ignored rdsel0", v, 3);
      wr(2, 5);
      rd(3, v); chk("R6 no period flag on write", v, 0);
      rd(2, v); chk("R6 count written", v, 5);
      pulse();
      rd(2, v); chk("R5 wrap after period", v, 0);
      rd(3, v); chk("R5 zero flag on wrap", v, 2);
      wr(3, 7);

      // delayed disable window
      wr(0, C_CPOL | C_RD);
      pulse(); pulse();
      rd(2, v); chk("R3 counts after disable", v, 2);
      chk("R3 still running", tmr_run, 1);
      pulse();
      rd(2, v); chk("R3 third edge counts", v, 3);
      chk("R3 stopped", tmr_run, 0);
      pulse();
      rd(2, v); chk("R3 held after window", v, 3);
      fire(2);
      rd(3, v); chk("R8 no capture flag idle", v, 0);
      wr(0, C_CPOL);
      rd(2, v); chk("R7 capture while idle", v, 3);

      // stop event
      wr(0, 16'hCF);
      pulse(); pulse(); pulse();
      fire(0);
      chk("R2 rerun", tmr_run, 1);
      pulse(); pulse();
      chk("R11 pulse at match", tmr_out, 1);
      fire(1);
      chk("R9 stop clears run", tmr_run, 0);
      rd(0, v); chk("R9 stop clears enable", v, 16'h4F);
      pulse(); pulse(); pulse();
      rd(2, v); chk("R9 count holds", v, 5);
      wr(0, C_CPOL);
      rd(2, v); chk("R7 stop loads capture", v, 5);
      wr(3, 7);

      // toggle mode, immediate
      sync_sel = 1'b0;
      wr(0, C_RD); wr(1, 2); wr(2, 0); wr(3, 7);
      wr(0, C_EN | C_CPOL | C_OM | C_RD);
      fire(0);
      begin
         int m;
         m = 0;
         for (int k = 1; k <= 6; k++) begin
            pulse();
            if (k % 3 == 2) m++;
            rd(2, v); chk("R12 count", v, k % 3);
            chk("R12 toggle out", tmr_out, m & 1);
            if (k == 2) begin
               rd(3, v); chk("R10 flag without enable", v[2], 1);
               chk("R10 irq masked", tmr_irq, 0);
            end
         end
      end

      // edge polarity latch
      wr(0, C_RD); wr(2, 0); wr(3, 7);
      wr(0, C_EN | C_RD);
      fire(0);
      half(1'b1);
      rd(2, v); chk("R4 no count on rise", v, 0);
      half(1'b0);
      rd(2, v); chk("R4 count on fall", v, 1);
      wr(0, C_EN | C_CPOL | C_RD);
      half(1'b1);
      rd(2, v); chk("R4 polarity not relatched", v, 1);
      half(1'b0);
      rd(2, v); chk("R4 still falling edge", v, 2);

      // idle level while disabled
      wr(0, C_OPOL);
      repeat (2) @(negedge clk);
      chk("R12 idle high disabled", tmr_out, 1);
      wr(0, 0);
      chk("R12 idle low disabled", tmr_out, 0);

      summary();
      $finish;
   end
endmodule